// File: doc/BRIEF.md
# I2C Register-Access Master Sequencer

This block is the host side of an I2C link to a target whose registers have 16-bit addresses. One command strobe starts a whole combined transaction. The block sends the device address byte, the two register-address bytes and the write data, or it reads back a counted run of bytes after a repeated START. Read bytes leave on a one-cycle valid strobe. Write bytes are pulled from the host one at a time. A done pulse and a NACK error flag close every transaction.

The bus pins are open-drain enables: a 1 pulls the line low. The bit timing comes from a divider parameter. Every bit slot is four quarter-phases of `QDIV` clock cycles each. The block does not arbitrate against other masters. It does not accept clock stretching by the target and it has no 10-bit addressing.

Top module: `i2c_regseq`

## Requirements
- R1: After reset, `busy`, `done`, `rd_valid`, `nack_err`, `wr_pull`, `scl_oe` and `sda_oe` are all low, so both lines are released.
- R2: Each transaction opens with a START and then one byte made of `cmd_dev` followed by a direction bit (0 = write, 1 = read). `cmd_op` selects the operation: 2'b00 write, 2'b01 random read, 2'b1x current-location read.
- R3: For write and random read, the register address follows the first byte as two bytes, high byte first. The target must ACK each of them.
- R4: A write sends exactly L data bytes after the register address and then a STOP. Each data byte is taken from `wr_byte` in the cycle `wr_pull` pulses, with one pulse per byte.
- R5: A random read sends the write-direction byte and the register address, then a repeated START and the read-direction byte. It then receives L bytes, each delivered with a one-cycle `rd_valid` pulse on `rd_byte`.
- R6: A current-location read has a single START. The read-direction byte follows it directly, with no register-address phase.
- R7: While reading, the master ACKs every byte except the last and NACKs the last one. Exactly L bytes are transferred. A `cmd_len` of 0 is treated as 1.
- R8: While SCL is high, SDA changes only to form START or STOP. Consecutive SCL rising edges inside a transaction are 4*QDIV cycles apart.
- R9: If the target NACKs an address, register or write byte, the master sends no further byte. It issues a STOP, sets `nack_err` (held until the next accepted command) and pulses `done`.
- R10: `busy` rises the cycle after an accepted strobe and stays high until the STOP completes. `done` pulses for one cycle, in the first cycle with `busy` low. Strobes while `busy` is high are ignored. A strobe in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 00 write, 01 random read, 1x current-location read |
| cmd_dev | input | 7 | Target device address |
| cmd_reg | input | 16 | Register address |
| cmd_len | input | LEN_W | Byte count L (0 acts as 1) |
| wr_byte | input | 8 | Write data byte, taken when wr_pull is high |
| wr_pull | output | 1 | Pulse: current wr_byte consumed |
| rd_valid | output | 1 | Pulse: rd_byte holds a received byte |
| rd_byte | output | 8 | Received byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| nack_err | output | 1 | Last transaction was aborted by a target NACK |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
The end of one transaction and the acceptance of the next command can fall in the same cycle. A strobe arriving in the `done` cycle must start the next transaction at once. A strobe held high during the earlier transaction must not disturb it. The bench provokes this by keeping `cmd_start` high across a whole random read while the command fields change to a current-location read. It then checks three things: the target model has seen no extra START while `busy` was high, `busy` is low in the `done` cycle and high in the cycle after, and both transactions return the bytes the shadow register model predicts.

// File: rtl/i2c_regseq_pkg.sv
package i2c_regseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_REGHI,
    ST_REGLO,
    ST_WDATA,
    ST_RSTART,
    ST_RDATA,
    ST_STOP
  } seq_st_e;

  typedef enum logic [1:0] {
    SK_BIT,
    SK_START,
    SK_STOP
  } slot_kind_e;

  localparam logic [1:0] OP_WRITE   = 2'b00;
  localparam logic [1:0] OP_RAND_RD = 2'b01;

endpackage

// File: rtl/i2c_regseq_timebase.sv
module i2c_regseq_timebase #(
  parameter int QDIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  output logic [1:0] quarter,
  output logic       q_end,
  output logic       slot_end
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    qtr_d;

  always_comb begin
    q_end    = en && (cnt_q == CW'(QDIV - 1));
    slot_end = q_end && (quarter == 2'd3);
    cnt_d    = cnt_q;
    qtr_d    = quarter;
    if (!en) begin
      cnt_d = '0;
      qtr_d = 2'd0;
    end else if (q_end) begin
      cnt_d = '0;
      qtr_d = quarter + 2'd1;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      quarter <= 2'd0;
    end else begin
      cnt_q   <= cnt_d;
      quarter <= qtr_d;
    end
  end

endmodule

// File: rtl/i2c_regseq_pins.sv
module i2c_regseq_pins
  import i2c_regseq_pkg::*;
(
  input  slot_kind_e kind,
  input  logic [1:0] quarter,
  input  logic       bit_val,
  output logic       scl_low,
  output logic       sda_low
);
  always_comb begin
    case (kind)
      SK_START: begin
        scl_low = (quarter == 2'd0) || (quarter == 2'd3);
        sda_low = quarter[1];
      end
      SK_STOP: begin
        scl_low = (quarter == 2'd0);
        sda_low = !quarter[1];
      end
      default: begin
        scl_low = (quarter == 2'd0) || (quarter == 2'd3);
        sda_low = !bit_val;
      end
    endcase
  end
endmodule

// File: rtl/i2c_regseq.sv
module i2c_regseq
  import i2c_regseq_pkg::*;
#(
  parameter int QDIV  = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_op,
  input  logic [6:0]       cmd_dev,
  input  logic [15:0]      cmd_reg,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [7:0]       wr_byte,
  output logic             wr_pull,
  output logic             rd_valid,
  output logic [7:0]       rd_byte,
  output logic             busy,
  output logic             done,
  output logic             nack_err,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_i
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  seq_st_e          st_q, st_d;
  logic [3:0]       bitn_q, bitn_d;
  logic [7:0]       sh_q, sh_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [1:0]       op_q, op_d;
  logic [6:0]       dev_q, dev_d;
  logic [15:0]      reg_q, reg_d;
  logic             dir_rd_q, dir_rd_d;
  logic             samp_q, samp_d;
  logic             err_d, done_d, rdv_d;
  logic [7:0]       rdb_d;
  logic [1:0]       quarter;
  logic             q_end, slot_end;
  slot_kind_e       kind, kind_q;
  logic             bit_val, scl_low, sda_low, last;

  assign busy = (st_q != ST_IDLE);
  assign last = (cnt_q == LEN_W'(1));

  i2c_regseq_timebase #(.QDIV(QDIV)) tb_i (
    .clk(clk), .rst_n(rst_n), .en(busy),
    .quarter(quarter), .q_end(q_end), .slot_end(slot_end)
  );

  always_comb begin
    kind    = SK_BIT;
    bit_val = 1'b1;
    case (st_q)
      ST_START, ST_RSTART: kind = SK_START;
      ST_STOP:             kind = SK_STOP;
      ST_RDATA:            bit_val = (bitn_q == ACK_SLOT) ? last : 1'b1;
      ST_ADDR, ST_REGHI, ST_REGLO, ST_WDATA:
                           bit_val = (bitn_q == ACK_SLOT) ? 1'b1 : sh_q[7];
      default: ;
    endcase
  end

  i2c_regseq_pins pins_i (
    .kind(kind), .quarter(quarter), .bit_val(bit_val),
    .scl_low(scl_low), .sda_low(sda_low)
  );

  always_comb begin
    st_d     = st_q;
    bitn_d   = bitn_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    op_d     = op_q;
    dev_d    = dev_q;
    reg_d    = reg_q;
    dir_rd_d = dir_rd_q;
    samp_d   = samp_q;
    err_d    = nack_err;
    done_d   = 1'b0;
    rdv_d    = 1'b0;
    rdb_d    = rd_byte;
    wr_pull  = 1'b0;
    if (st_q == ST_IDLE) begin
      if (cmd_start) begin
        st_d  = ST_START;
        op_d  = cmd_op;
        dev_d = cmd_dev;
        reg_d = cmd_reg;
        cnt_d = (cmd_len == '0) ? LEN_W'(1) : cmd_len;
        err_d = 1'b0;
      end
    end else begin
      if (q_end && quarter == 2'd2) begin
        samp_d = sda_i;
        if (st_q == ST_RDATA && bitn_q != ACK_SLOT) sh_d = {sh_q[6:0], sda_i};
      end
      if (slot_end) begin
        case (st_q)
          ST_START, ST_RSTART: begin
            st_d     = ST_ADDR;
            bitn_d   = 4'd0;
            dir_rd_d = (st_q == ST_RSTART) || op_q[1];
            sh_d     = {dev_q, dir_rd_d};
          end
          ST_ADDR, ST_REGHI, ST_REGLO, ST_WDATA: begin
            if (bitn_q != ACK_SLOT) begin
              sh_d   = {sh_q[6:0], 1'b0};
              bitn_d = bitn_q + 4'd1;
            end else begin
              bitn_d = 4'd0;
              if (samp_q) begin
                err_d = 1'b1;
                st_d  = ST_STOP;
              end else begin
                case (st_q)
                  ST_ADDR: begin
                    st_d = dir_rd_q ? ST_RDATA : ST_REGHI;
                    sh_d = reg_q[15:8];
                  end
                  ST_REGHI: begin
                    st_d = ST_REGLO;
                    sh_d = reg_q[7:0];
                  end
                  ST_REGLO: begin
                    if (op_q == OP_WRITE) begin
                      st_d    = ST_WDATA;
                      sh_d    = wr_byte;
                      wr_pull = 1'b1;
                    end else begin
                      st_d = ST_RSTART;
                    end
                  end
                  default: begin
                    if (last) begin
                      st_d = ST_STOP;
                    end else begin
                      cnt_d   = cnt_q - LEN_W'(1);
                      sh_d    = wr_byte;
                      wr_pull = 1'b1;
                    end
                  end
                endcase
              end
            end
          end
          ST_RDATA: begin
            if (bitn_q == 4'd7) begin
              rdv_d = 1'b1;
              rdb_d = sh_q;
            end
            if (bitn_q != ACK_SLOT) begin
              bitn_d = bitn_q + 4'd1;
            end else if (last) begin
              st_d = ST_STOP;
            end else begin
              bitn_d = 4'd0;
              cnt_d  = cnt_q - LEN_W'(1);
            end
          end
          ST_STOP: begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      bitn_q   <= 4'd0;
      sh_q     <= 8'd0;
      cnt_q    <= '0;
      op_q     <= 2'd0;
      dev_q    <= 7'd0;
      reg_q    <= 16'd0;
      dir_rd_q <= 1'b0;
      samp_q   <= 1'b1;
      nack_err <= 1'b0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rd_byte  <= 8'd0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      kind_q   <= SK_BIT;
    end else begin
      st_q     <= st_d;
      bitn_q   <= bitn_d;
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      op_q     <= op_d;
      dev_q    <= dev_d;
      reg_q    <= reg_d;
      dir_rd_q <= dir_rd_d;
      samp_q   <= samp_d;
      nack_err <= err_d;
      done     <= done_d;
      rd_valid <= rdv_d;
      rd_byte  <= rdb_d;
      scl_oe   <= busy && scl_low;
      sda_oe   <= busy && sda_low;
      kind_q   <= kind;
    end
  end

  // R8
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> (kind_q != SK_BIT));

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  rd_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  // R9
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> (st_q == ST_STOP));

  // R4
  pull_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pull |-> (busy && !sda_oe && !scl_oe) || busy);

endmodule

// File: tb/i2c_regseq_tb_top.sv
`timescale 1ns/1ps
module i2c_regseq_tb_top;
  localparam int QDIV = 4;
  localparam logic [6:0] SLV = 7'h3C;

  logic        clk, rst_n;
  logic        cmd_start;
  logic [1:0]  cmd_op;
  logic [6:0]  cmd_dev;
  logic [15:0] cmd_reg;
  logic [7:0]  cmd_len;
  logic [7:0]  wr_byte;
  logic        wr_pull, rd_valid, busy, done, nack_err, scl_oe, sda_oe;
  logic [7:0]  rd_byte;
  logic        s_low, scl_ln, sda_ln;

  int n_chk = 0, n_err = 0, cyc = 0;
  int pull_n, rd_cnt, n_start, n_stop, nack_idx;
  int bad_period, n_rise, last_rise;
  logic [7:0]  wbuf [16];
  logic [7:0]  shadow [256];
  logic [7:0]  mem [256];
  logic [15:0] cur_ptr;
  logic [7:0]  exp_rd [$];
  logic [23:0] exp_wr [$];

  assign scl_ln  = !scl_oe;
  assign sda_ln  = !(sda_oe || s_low);
  assign wr_byte = wbuf[pull_n[3:0]];

  i2c_regseq #(.QDIV(QDIV), .LEN_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_len(cmd_len),
    .wr_byte(wr_byte), .wr_pull(wr_pull), .rd_valid(rd_valid),
    .rd_byte(rd_byte), .busy(busy), .done(done), .nack_err(nack_err),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_ln)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected <190000", cyc);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  always @(posedge clk) if (wr_pull) pull_n++;

  // R8 period monitor
  logic p_scl;
  always @(posedge clk) begin
    p_scl <= scl_ln;
    if (!busy) last_rise <= -1;
    else if (!p_scl && scl_ln) begin
      n_rise++;
      if (last_rise >= 0 && (cyc - last_rise) != 4 * QDIV) bad_period++;
      last_rise <= cyc;
    end
  end

  // scoreboard monitor for read data
  always @(negedge clk) begin
    if (rd_valid) begin
      rd_cnt++;
      if (exp_rd.size() == 0) chk(0, "R7", "unexpected read byte", rd_byte, 0);
      else begin
        logic [7:0] e;
        e = exp_rd.pop_front();
        chk(rd_byte == e, "R5", "read byte", rd_byte, e);
      end
    end
  end

  // target model
  typedef enum {T_IDLE, T_RX, T_ACK, T_TX, T_MACK} tst_e;
  tst_e ts;
  logic sp_scl, sp_sda, rw, mack;
  logic [7:0] tsh;
  logic [15:0] ptr;
  int bc, bidx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts <= T_IDLE; s_low <= 1'b0; sp_scl <= 1'b1; sp_sda <= 1'b1;
      bc <= 0; bidx <= 0; ptr <= 16'd0; rw <= 1'b0; mack <= 1'b1; tsh <= 8'd0;
    end else begin
      sp_scl <= scl_ln;
      sp_sda <= sda_ln;
      if (sp_scl && scl_ln && sp_sda && !sda_ln) begin
        ts <= T_RX; bc <= 0; bidx <= 0; s_low <= 1'b0; n_start++;
      end else if (sp_scl && scl_ln && !sp_sda && sda_ln) begin
        ts <= T_IDLE; s_low <= 1'b0; n_stop++;
      end else if (!sp_scl && scl_ln) begin
        if (ts == T_RX) begin tsh <= {tsh[6:0], sda_ln}; bc <= bc + 1; end
        else if (ts == T_MACK) mack <= sda_ln;
      end else if (sp_scl && !scl_ln) begin
        case (ts)
          T_RX: if (bc == 8) begin
            bidx <= bidx + 1;
            if (bidx == 0) begin
              if (tsh[7:1] == SLV && nack_idx != 0) begin
                rw <= tsh[0]; s_low <= 1'b1; ts <= T_ACK;
              end else ts <= T_IDLE;
            end else if (bidx == nack_idx) ts <= T_IDLE;
            else begin
              s_low <= 1'b1; ts <= T_ACK;
              if (bidx == 1) ptr[15:8] <= tsh;
              else if (bidx == 2) ptr[7:0] <= tsh;
              else begin
                mem[ptr[7:0]] <= tsh;
                ptr <= ptr + 16'd1;
                if (exp_wr.size() == 0) chk(0, "R4", "unexpected write", tsh, 0);
                else begin
                  logic [23:0] e;
                  e = exp_wr.pop_front();
                  chk(e == {ptr, tsh}, "R3", "written addr/data", {ptr, tsh}, e);
                end
              end
            end
          end
          T_ACK: begin
            bc <= 0;
            if (rw) begin
              tsh <= mem[ptr[7:0]]; s_low <= !mem[ptr[7:0]][7];
              ptr <= ptr + 16'd1; ts <= T_TX;
            end else begin
              s_low <= 1'b0; ts <= T_RX;
            end
          end
          T_TX: begin
            if (bc == 7) begin s_low <= 1'b0; ts <= T_MACK; end
            else begin s_low <= !tsh[6]; tsh <= {tsh[6:0], 1'b0}; bc <= bc + 1; end
          end
          T_MACK: begin
            if (!mack) begin
              tsh <= mem[ptr[7:0]]; s_low <= !mem[ptr[7:0]][7];
              ptr <= ptr + 16'd1; bc <= 0; ts <= T_TX;
            end else begin
              s_low <= 1'b0; ts <= T_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  task automatic clear_counts();
    pull_n = 0; rd_cnt = 0; n_start = 0; n_stop = 0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [6:0] dev,
                       input logic [15:0] rg, input int len);
    @(negedge clk);
    cmd_op = op; cmd_dev = dev; cmd_reg = rg; cmd_len = 8'(len); cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after strobe", busy, 1);
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R10", "busy low in done cycle", busy, 0);
  endtask

  task automatic wr_txn(input logic [15:0] rg, input int len);
    clear_counts();
    for (int i = 0; i < len; i++) begin
      exp_wr.push_back({16'(rg + 16'(i)), wbuf[i]});
      shadow[8'(rg + 16'(i))] = wbuf[i];
    end
    issue(2'b00, SLV, rg, len);
    cur_ptr = rg + 16'(len);
    chk(nack_err == 1'b0, "R9", "no error on write", nack_err, 0);
    chk(pull_n == len, "R4", "pull count", pull_n, len);
    chk(n_start == 1 && n_stop == 1, "R4", "write start/stop", n_start * 16 + n_stop, 17);
    chk(exp_wr.size() == 0, "R3", "writes pending", exp_wr.size(), 0);
  endtask

  task automatic rd_txn(input logic [15:0] rg, input int len, input bit random);
    int l;
    logic [15:0] s;
    l = (len == 0) ? 1 : len;
    s = random ? rg : cur_ptr;
    clear_counts();
    for (int i = 0; i < l; i++) exp_rd.push_back(shadow[8'(s + 16'(i))]);
    cur_ptr = s + 16'(l);
    issue(random ? 2'b01 : 2'b10, SLV, rg, len);
    chk(rd_cnt == l, "R7", "bytes read", rd_cnt, l);
    chk(exp_rd.size() == 0, "R5", "reads pending", exp_rd.size(), 0);
    if (random) chk(n_start == 2, "R5", "starts in random read", n_start, 2);
    else        chk(n_start == 1, "R6", "starts in current read", n_start, 1);
    chk(n_stop == 1 && nack_err == 1'b0, "R7", "stop, no error", n_stop, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    for (int i = 0; i < 16; i++) wbuf[i] = 8'h00;
    cmd_start = 1'b0; cmd_op = 2'b00; cmd_dev = 7'd0; cmd_reg = 16'd0; cmd_len = 8'd0;
    nack_idx = 99; bad_period = 0; n_rise = 0; last_rise = -1; cur_ptr = 16'd0;
    clear_counts();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !rd_valid && !nack_err && !wr_pull, "R1", "status at reset",
        {busy, done, rd_valid, nack_err, wr_pull}, 0);
    chk(!scl_oe && !sda_oe, "R1", "pins released at reset", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !scl_oe && !sda_oe, "R1", "idle after reset", {busy, scl_oe, sda_oe}, 0);

    // R2 R3 R4 random write of one word
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
    wr_txn(16'h0010, 2);
    // R2 R5 random read back
    rd_txn(16'h0010, 2, 1'b1);
    // R6 current-location read
    rd_txn(16'h0000, 1, 1'b0);
    // R7 sequential read
    rd_txn(16'h0040, 5, 1'b1);
    rd_txn(16'h0000, 3, 1'b0);
    // R4 sequential write and read back
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'hC4;
    wr_txn(16'h0080, 4);
    rd_txn(16'h0080, 4, 1'b1);
    // R7 zero length reads one byte
    rd_txn(16'h0020, 0, 1'b1);

    // R9 wrong device address
    clear_counts();
    issue(2'b01, 7'h21, 16'h0010, 2);
    chk(nack_err == 1'b1, "R9", "error on address nack", nack_err, 1);
    chk(rd_cnt == 0 && n_stop == 1 && n_start == 1, "R9", "abort shape",
        rd_cnt * 256 + n_start * 16 + n_stop, 17);

    // R9 register byte nack
    nack_idx = 1;
    clear_counts();
    issue(2'b00, SLV, 16'h0090, 2);
    chk(nack_err == 1'b1 && pull_n == 0, "R9", "register nack", pull_n, 0);
    chk(n_stop == 1, "R9", "stop after register nack", n_stop, 1);

    // R9 data byte nack: only the first data byte is pulled, nothing stored
    nack_idx = 3;
    clear_counts();
    wbuf[0] = 8'hEE; wbuf[1] = 8'hDD; wbuf[2] = 8'hCC;
    issue(2'b00, SLV, 16'h0090, 3);
    chk(nack_err == 1'b1, "R9", "error on data nack", nack_err, 1);
    chk(pull_n == 1, "R9", "bytes pulled before abort", pull_n, 1);
    nack_idx = 99;
    rd_txn(16'h0090, 3, 1'b1);

    // R10 strobe held through a transaction, accepted in the done cycle
    clear_counts();
    exp_rd.push_back(shadow[8'h40]); exp_rd.push_back(shadow[8'h41]);
    exp_rd.push_back(shadow[8'h42]);
    @(negedge clk);
    cmd_op = 2'b01; cmd_dev = SLV; cmd_reg = 16'h0040; cmd_len = 8'd2; cmd_start = 1'b1;
    @(negedge clk);
    cmd_op = 2'b10; cmd_reg = 16'h00F0; cmd_len = 8'd1;
    chk(busy == 1'b1, "R10", "busy while strobe held", busy, 1);
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R10", "busy low in done cycle", busy, 0);
    chk(n_start == 2 && rd_cnt == 2, "R10", "held strobe ignored while busy",
        n_start * 16 + rd_cnt, 34);
    @(negedge clk);
    cmd_start = 1'b0;
    chk(busy == 1'b1, "R10", "accepted in done cycle", busy, 1);
    while (!done) @(negedge clk);
    chk(rd_cnt == 3 && n_start == 3 && exp_rd.size() == 0, "R10", "second command result",
        rd_cnt * 16 + n_start, 51);
    cur_ptr = 16'h0043;

    // R8 bit timing
    chk(bad_period == 0 && n_rise > 0, "R8", "SCL rise spacing", bad_period, 0);

    repeat (4) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy, "R1", "idle at end", {scl_oe, sda_oe, busy}, 0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule